// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter with Selectable Bit-Clock Edge

The block takes one stereo pair of 24-bit converter samples and sends both channels, one after the other, on a single serial data line. It works as a timing slave: the bit clock and the frame clock come from outside. Both clocks are oversampled by the block's system clock and must be synchronous to it, with each clock level lasting at least two system-clock cycles. A polarity input chooses which bit-clock edge samples the frame clock. The data line always changes on the other edge, so a receiver can sample it cleanly on the sampling edge.

Software writes a new pair with a one-cycle load strobe. The pair waits in a holding register and goes out from the next left-channel half-frame. A two-bit format select picks the alignment and the word length. The four choices are left-aligned with a one-slot delay (I2S, 16 or 24 bits) and right-aligned (24 or 20 bits). In the right-aligned modes the block measures how many bit slots the previous half-frame held and places the LSB in the last slot before the frame-clock transition.

Top module: `audio_ser_tx`

## Requirements
- R1: During and right after reset, `sdata_o` is 0.
- R2: With `pol_i`=0, the frame clock is sampled on rising bit-clock edges and `sdata_o` changes only in the system cycle after a falling bit-clock edge.
- R3: With `pol_i`=1 the two edges swap: the frame clock is sampled on falling edges and `sdata_o` changes only after rising edges.
- R4: `fmt_i` encoding: 2'b00 right-aligned 24-bit, 2'b01 right-aligned 20-bit, 2'b10 I2S 16-bit, 2'b11 I2S 24-bit. In I2S modes the left channel is sent while the frame clock is low, and the MSB is sampled at the second sampling edge of each half-frame. The first sampling edge is the one that sees the frame-clock transition.
- R5: In right-aligned modes the left channel is sent while the frame clock is high. The LSB is sampled at the last sampling edge before the next transition, and the slot count is taken from the half-frame just before.
- R6: The word length is 24, 20 or 16 bits according to `fmt_i`. Shorter words keep the upper bits of the 24-bit sample, and the lower bits are dropped.
- R7: Every slot of a half-frame outside the word carries 0.
- R8: If no load happens between two frame starts, the next frame repeats the previous pair.
- R9: A pair loaded in the middle of a frame does not change that frame. It is sent from the next left half-frame onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples both serial clocks |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Bit clock, synchronous to clk_i |
| lrclk_i | input | 1 | Frame clock, synchronous to clk_i |
| pol_i | input | 1 | Edge polarity select (R2, R3) |
| fmt_i | input | 2 | Frame format and word length select (R4) |
| load_i | input | 1 | One-cycle strobe that captures left_i and right_i |
| left_i | input | 24 | Left-channel sample |
| right_i | input | 24 | Right-channel sample |
| sdata_o | output | 1 | Serial data output |

## Verification
The bench uses the default parameters: 24-bit samples and a 6-bit slot counter, which allows half-frames of up to 63 slots. With these values it runs half-frames of 32 slots, which leave padding slots after even a 24-bit I2S word, and of 28 slots, which show that the right-aligned offset follows the measured length. The sample patterns have non-zero low bits, so a wrongly truncated word shows up as a set bit in a padding slot. Every format is run, both polarities are used, and mid-frame loads are compared with frames that have no load at all.

// File: rtl/audio_ser_tx_pkg.sv
package audio_ser_tx_pkg;
  typedef enum logic [1:0] {
    FMT_RJ24  = 2'b00,
    FMT_RJ20  = 2'b01,
    FMT_I2S16 = 2'b10,
    FMT_I2S24 = 2'b11
  } fmt_e;

  function automatic int unsigned fmt_word_len(fmt_e f);
    case (f)
      FMT_RJ20:  return 20;
      FMT_I2S16: return 16;
      default:   return 24;
    endcase
  endfunction

  function automatic logic fmt_is_i2s(fmt_e f);
    return f[1];
  endfunction
endpackage

// File: rtl/tx_edge_det.sv
module tx_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic pol_i,
  output logic smp_ev_o,
  output logic drv_ev_o
);
  logic bclk_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_q <= 1'b0;
    else         bclk_q <= bclk_i;
  end

  assign rise = bclk_i & ~bclk_q;
  assign fall = ~bclk_i & bclk_q;

  // polarity swaps both edges together
  assign smp_ev_o = pol_i ? fall : rise;
  assign drv_ev_o = pol_i ? rise : fall;
endmodule

// File: rtl/tx_frame_trk.sv
module tx_frame_trk #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_ev_i,
  input  logic             lrclk_i,
  output logic             lr_o,
  output logic             chg_o,
  output logic [CNT_W-1:0] idx_o,
  output logic [CNT_W-1:0] half_len_o
);
  localparam logic [CNT_W-1:0] IdxMax = '1;

  logic             lr_q;
  logic [CNT_W-1:0] idx_q, len_q;

  assign chg_o = smp_ev_i && (lrclk_i != lr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_q  <= 1'b0;
      idx_q <= '0;
      len_q <= '0;
    end else if (chg_o) begin
      lr_q  <= lrclk_i;
      idx_q <= '0;
      len_q <= idx_q + CNT_W'(1);
    end else if (smp_ev_i && idx_q != IdxMax) begin
      idx_q <= idx_q + CNT_W'(1);
    end
  end

  assign lr_o       = lr_q;
  assign idx_o      = idx_q;
  assign half_len_o = len_q;

  // R5
  len_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chg_o |=> $stable(half_len_o));
endmodule

// File: rtl/tx_bit_sel.sv
module tx_bit_sel #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned CNT_W    = 6
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [CNT_W-1:0]    idx_i,
  input  logic [CNT_W-1:0]    half_len_i,
  input  logic [CNT_W-1:0]    wlen_i,
  input  logic                i2s_i,
  output logic                bit_o
);
  localparam int unsigned KW = CNT_W + 2;

  logic signed [KW-1:0] k, k_rj, k_i2s, w_s;
  logic [SAMPLE_W-1:0]  shifted;
  logic                 in_word;

  // k: position inside the word of the bit the receiver samples next
  assign k_i2s = $signed({2'b00, idx_i});
  assign k_rj  = $signed({2'b00, idx_i} + KW'(1)) - $signed({2'b00, half_len_i})
               + $signed({2'b00, wlen_i});
  assign w_s   = $signed({2'b00, wlen_i});
  assign k     = i2s_i ? k_i2s : k_rj;

  assign in_word = !k[KW-1] && (k < w_s);
  assign shifted = sample_i << k[KW-2:0];
  assign bit_o   = in_word & shifted[SAMPLE_W-1];
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import audio_ser_tx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned CNT_W    = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bclk_i,
  input  logic                lrclk_i,
  input  logic                pol_i,
  input  logic [1:0]          fmt_i,
  input  logic                load_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                sdata_o
);
  fmt_e                fmt;
  logic                i2s, left_lvl;
  logic [CNT_W-1:0]    wlen;
  logic                smp_ev, drv_ev, chg, lr_cur;
  logic [CNT_W-1:0]    idx, half_len;
  logic                frame_start, send_left, nxt_bit;
  logic [SAMPLE_W-1:0] pend_l, pend_r, act_l, act_r, cur;

  assign fmt      = fmt_e'(fmt_i);
  assign i2s      = fmt_is_i2s(fmt);
  assign wlen     = CNT_W'(fmt_word_len(fmt));
  assign left_lvl = ~i2s;

  tx_edge_det i_edge (
    .clk_i, .rst_ni, .bclk_i, .pol_i,
    .smp_ev_o(smp_ev), .drv_ev_o(drv_ev)
  );

  tx_frame_trk #(.CNT_W(CNT_W)) i_trk (
    .clk_i, .rst_ni, .smp_ev_i(smp_ev), .lrclk_i,
    .lr_o(lr_cur), .chg_o(chg), .idx_o(idx), .half_len_o(half_len)
  );

  assign frame_start = chg && (lrclk_i == left_lvl);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_l <= '0;
      pend_r <= '0;
    end else if (load_i) begin
      pend_l <= left_i;
      pend_r <= right_i;
    end
  end

  // pair only moves to the shifter at a frame start; otherwise it repeats
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_l <= '0;
      act_r <= '0;
    end else if (frame_start) begin
      act_l <= pend_l;
      act_r <= pend_r;
    end
  end

  assign send_left = (lr_cur == left_lvl);
  assign cur       = send_left ? act_l : act_r;

  tx_bit_sel #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) i_sel (
    .sample_i(cur), .idx_i(idx), .half_len_i(half_len),
    .wlen_i(wlen), .i2s_i(i2s), .bit_o(nxt_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sdata_o <= 1'b0;
    else if (drv_ev) sdata_o <= nxt_bit;
  end

  // R2 R3
  drv_edge_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_ev |=> $stable(sdata_o));

  // R9
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start |=> ($stable(act_l) && $stable(act_r)));

  // R7
  i2s_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_ev && i2s && (idx >= wlen)) |=> !sdata_o);
endmodule

// File: tb/test_audio_ser_tx.sv
module test_audio_ser_tx;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bclk_i = 1'b1;
  logic        lrclk_i = 1'b0;
  logic        pol_i = 1'b0;
  logic [1:0]  fmt_i = 2'b00;
  logic        load_i = 1'b0;
  logic [23:0] left_i = '0;
  logic [23:0] right_i = '0;
  logic        sdata_o;

  int errors = 0;
  int checks = 0;

  audio_ser_tx i_audio_ser_tx (.*);

  always #10ns clk_i = ~clk_i;

  function automatic logic exp_bit(logic [23:0] s, logic [1:0] f, int n, int j);
    int w, k;
    w = (f == 2'b01) ? 20 : (f == 2'b10) ? 16 : 24;
    k = f[1] ? j - 1 : j - (n - w);
    if (k < 0 || k >= w) return 1'b0;
    return s[23-k];
  endfunction

  task automatic check(logic ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_load(logic [23:0] l, logic [23:0] r);
    @(negedge clk_i);
    left_i = l; right_i = r; load_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic slot(logic lr, output logic got, output logic stab);
    @(negedge clk_i);
    bclk_i = pol_i;   // drive edge: falling when pol=0, rising when pol=1
    lrclk_i = lr;
    repeat (4) @(negedge clk_i);
    got = sdata_o;
    bclk_i = ~pol_i;  // sampling edge
    stab = 1'b1;
    repeat (4) begin
      @(negedge clk_i);
      if (sdata_o !== got) stab = 1'b0;
    end
  endtask

  task automatic run_half(logic lr, int n, logic [23:0] s, logic chk, string req);
    logic [63:0] got, exp;
    logic b, st, all_st;
    got = '0; exp = '0; all_st = 1'b1;
    for (int j = 0; j < n; j++) begin
      slot(lr, b, st);
      got[j] = b;
      exp[j] = exp_bit(s, fmt_i, n, j);
      all_st &= st;
    end
    if (chk) begin
      check(got === exp, req, "half-frame bits", got, exp);
      check(all_st, pol_i ? "R3" : "R2", "data moved outside drive edge", {63'd0, all_st}, 64'd1);
    end
  endtask

  task automatic run_frame(int n, logic [23:0] l, logic [23:0] r, logic chk, string req,
                           logic mid, logic [23:0] ml, logic [23:0] mr);
    logic left_lvl;
    left_lvl = ~fmt_i[1];
    run_half(left_lvl, n, l, chk, req);
    if (mid) do_load(ml, mr);
    run_half(~left_lvl, n, r, chk, req);
  endtask

  task automatic setup(logic pol, logic [1:0] fmt);
    @(negedge clk_i);
    pol_i = pol; fmt_i = fmt;
    @(negedge clk_i);
    bclk_i = ~pol;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic t_reset;
    check(sdata_o === 1'b0, "R1", "sdata in reset", {63'd0, sdata_o}, 64'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(sdata_o === 1'b0, "R1", "sdata after reset", {63'd0, sdata_o}, 64'd0);
  endtask

  task automatic t_rj24;
    setup(1'b0, 2'b00);
    do_load(24'hA5C3F1, 24'h3C5A97);
    run_frame(32, 24'hA5C3F1, 24'h3C5A97, 1'b0, "", 1'b0, '0, '0);
    run_frame(32, 24'hA5C3F1, 24'h3C5A97, 1'b1, "R5 R6", 1'b0, '0, '0);
  endtask

  task automatic t_rj20_short;
    setup(1'b0, 2'b01);
    do_load(24'hF0F0FF, 24'h12345F);
    run_frame(28, 24'hF0F0FF, 24'h12345F, 1'b0, "", 1'b0, '0, '0);
    run_frame(28, 24'hF0F0FF, 24'h12345F, 1'b1, "R5 R6 R7", 1'b0, '0, '0);
  endtask

  task automatic t_i2s16;
    setup(1'b0, 2'b10);
    do_load(24'h9ABCFF, 24'hC0FFEE);
    run_frame(32, 24'h9ABCFF, 24'hC0FFEE, 1'b0, "", 1'b0, '0, '0);
    run_frame(32, 24'h9ABCFF, 24'hC0FFEE, 1'b1, "R4 R6 R7", 1'b0, '0, '0);
  endtask

  task automatic t_i2s24_pol;
    setup(1'b1, 2'b11);
    do_load(24'hD00D1B, 24'h5EED07);
    run_frame(32, 24'hD00D1B, 24'h5EED07, 1'b0, "", 1'b0, '0, '0);
    run_frame(32, 24'hD00D1B, 24'h5EED07, 1'b1, "R3 R4", 1'b0, '0, '0);
  endtask

  task automatic t_rj_pol;
    setup(1'b1, 2'b00);
    do_load(24'h81E7A3, 24'h7E185C);
    run_frame(32, 24'h81E7A3, 24'h7E185C, 1'b0, "", 1'b0, '0, '0);
    run_frame(32, 24'h81E7A3, 24'h7E185C, 1'b1, "R3 R5", 1'b0, '0, '0);
  endtask

  task automatic t_repeat;
    setup(1'b0, 2'b11);
    do_load(24'h6B2E91, 24'hB4D7C8);
    run_frame(32, 24'h6B2E91, 24'hB4D7C8, 1'b0, "", 1'b0, '0, '0);
    run_frame(32, 24'h6B2E91, 24'hB4D7C8, 1'b1, "R8", 1'b0, '0, '0);
    run_frame(32, 24'h6B2E91, 24'hB4D7C8, 1'b1, "R8", 1'b0, '0, '0);
  endtask

  task automatic t_midload;
    setup(1'b0, 2'b00);
    do_load(24'h111111, 24'h222222);
    run_frame(32, 24'h111111, 24'h222222, 1'b0, "", 1'b0, '0, '0);
    run_frame(32, 24'h111111, 24'h222222, 1'b1, "R9", 1'b1, 24'hE3C1B5, 24'h4D2F99);
    run_frame(32, 24'hE3C1B5, 24'h4D2F99, 1'b1, "R9", 1'b0, '0, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    t_rj24();
    t_rj20_short();
    t_i2s16();
    t_i2s24_pol();
    t_rj_pol();
    t_repeat();
    t_midload();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule